// File: doc/BRIEF.md
# Weight-Class Compressor Population Counter

This block returns how many bits are set in an N-bit input word. The bits are not summed by a chain of adders. They are reduced column by column, one column per bit weight. Each column is cut into triples, and each triple feeds a full adder acting as a 3:2 compressor. The sum bit stays in the same column and the carry bit moves up one column. Passes repeat until every column holds one bit. Those bits, read from the lowest weight upward, form the binary count. A column that ends a pass with one bit left over passes it through unchanged. A column with two bits left over sends them through a half adder.

Each compression pass can be followed by a register, chosen by a bit mask parameter. A word can enter on every cycle, and the valid flag travels with the data. A saturating variant keeps the output in the range 0 to 3 and raises a flag when the true count is larger. The same flag is also driven in the full-count variant.

Top module: `popc_csa`

## Requirements
- R1: When `out_valid` is 1, `out_count` (full-count variant) equals the number of ones in the `in_word` that was accepted with it, for any width N from 4 to 255, including widths that are and are not multiples of three.
- R2: `out_count` is ceil(log2(N+1)) bits wide: 6 bits for N=32, 7 for N=64, 4 for N=10 and N=11.
- R3: Every compression pass keeps the weighted sum of its bits (a bit in column w counts as 2^w), and no carry ever leaves the topmost column.
- R4: A column whose height leaves one spare bit after the triples passes that bit unchanged. A column that leaves two spare bits sends them through a half adder. Both cases give exact counts (checked exhaustively at N=10 and N=11).
- R5: With K passes registered (bit l of `PIPE_MASK` set registers pass l), `out_valid` is `in_valid` delayed by exactly K cycles, and a new word is accepted on every cycle.
- R6: A synchronous active-high `rst` clears every registered valid stage in the cycle after it is sampled, even while `in_valid` is 1.
- R7: `out_over` is 1 exactly when the true count is greater than 3, in both variants.
- R8: With `SATURATE`=1, `out_count` equals the true count when the count is 0 to 3, and equals 3 (all upper bits 0) when the count is greater than 3.
- R9: With `PIPE_MASK`=0 the block is purely combinational: `out_valid` follows `in_valid`, and the result appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Marks `in_word` as a word to count |
| in_word | input | N | Word whose set bits are counted |
| out_valid | output | 1 | Marks `out_count` and `out_over` as a result |
| out_count | output | ceil(log2(N+1)) | Population count, or clamped count in the saturating variant |
| out_over | output | 1 | Count is greater than three |

## Verification
Two events can fall in the same cycle. One is a new word entering the first registered pass while an earlier word leaves the last one. The other is reset arriving while `in_valid` is high. The first is provoked by streaming words back to back for thousands of cycles, with occasional idle gaps, into a 32-bit instance with two registered passes and an exhaustively driven 11-bit saturating instance with three. The bench keeps its own history ring and expects the result of the word from K cycles earlier at each sample. The second is provoked by holding `in_valid` high through reset, at start-up and again in the middle of a run; `out_valid` is judged low on the following cycle.

// File: rtl/popc_pkg.sv
package popc_pkg;

  localparam int MAX_COLS = 32;
  localparam int HW = 8;  // bits per packed column height

  typedef logic [HW*MAX_COLS-1:0] heights_t;

  // Column heights before compression pass `lvl` (pass 0 sees the raw word).
  function automatic heights_t col_heights(input int n, input int ncols, input int lvl);
    int       h  [MAX_COLS];
    int       nh [MAX_COLS];
    heights_t r;
    for (int w = 0; w < MAX_COLS; w++) h[w] = 0;
    h[0] = n;
    for (int l = 0; l < lvl; l++) begin
      for (int w = 0; w < MAX_COLS; w++) nh[w] = 0;
      for (int w = 0; w < ncols; w++) begin
        nh[w] += (h[w] + 2) / 3;
        if (w + 1 < ncols) nh[w+1] += h[w] / 3 + ((h[w] % 3 == 2) ? 1 : 0);
      end
      for (int w = 0; w < MAX_COLS; w++) h[w] = nh[w];
    end
    r = '0;
    for (int w = 0; w < ncols; w++) r[HW*w +: HW] = HW'(h[w]);
    return r;
  endfunction

  function automatic int height_of(input heights_t r, input int w);
    return int'(r[HW*w +: HW]);
  endfunction

  // Number of passes until every column holds at most one bit.
  function automatic int tree_levels(input int n, input int ncols);
    heights_t r;
    int       lv;
    bit       more;
    lv   = 0;
    more = 1'b1;
    while (more && lv < 64) begin
      r    = col_heights(n, ncols, lv);
      more = 1'b0;
      for (int w = 0; w < ncols; w++) if (height_of(r, w) > 1) more = 1'b1;
      if (more) lv++;
    end
    return lv;
  endfunction

endpackage

// File: rtl/popc_fa.sv
module popc_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/popc_level.sv
module popc_level #(
  parameter int N   = 32,
  parameter int W   = 6,
  parameter int LVL = 0,
  parameter bit REG = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W*N-1:0] in_bits,
  output logic         out_valid,
  output logic [W*N-1:0] out_bits
);
  localparam int G = (N + 2) / 3;
  localparam popc_pkg::heights_t HT = popc_pkg::col_heights(N, W, LVL);

  logic [W*G-1:0] sm;    // sum bits, column w group g at w*G+g
  logic [W*G-1:0] cy;    // carry bits produced by column w
  logic [W*N-1:0] nxt;   // column bits after this pass

  // Weighted value of a column vector: a bit in column w is worth 2^w.
  function automatic int unsigned wsum(input logic [W*N-1:0] v);
    int unsigned t;
    t = 0;
    for (int w = 0; w < W; w++)
      for (int i = 0; i < N; i++)
        t += int'(v[w*N+i]) << w;
    return t;
  endfunction

  for (genvar w = 0; w < W; w++) begin : g_col
    localparam int H  = popc_pkg::height_of(HT, w);
    localparam int S  = (H + 2) / 3;
    localparam int HP = (w > 0) ? popc_pkg::height_of(HT, (w > 0) ? w - 1 : 0) : 0;
    localparam int CP = HP / 3 + ((HP % 3 == 2) ? 1 : 0);

    for (genvar g = 0; g < G; g++) begin : g_grp
      if (3*g + 3 <= H) begin : g_full
        popc_fa u_fa (.a(in_bits[w*N+3*g]), .b(in_bits[w*N+3*g+1]), .ci(in_bits[w*N+3*g+2]),
                      .s(sm[w*G+g]), .co(cy[w*G+g]));
      end else if (3*g + 2 == H) begin : g_half
        popc_fa u_ha (.a(in_bits[w*N+3*g]), .b(in_bits[w*N+3*g+1]), .ci(1'b0),
                      .s(sm[w*G+g]), .co(cy[w*G+g]));
      end else if (3*g + 1 == H) begin : g_pass
        assign sm[w*G+g] = in_bits[w*N+3*g];
        assign cy[w*G+g] = 1'b0;
      end else begin : g_none
        assign sm[w*G+g] = 1'b0;
        assign cy[w*G+g] = 1'b0;
      end
    end

    // Next column: own sums first, then carries arriving from column w-1.
    for (genvar i = 0; i < N; i++) begin : g_pack
      if (i < S) begin : g_s
        assign nxt[w*N+i] = sm[w*G+i];
      end else if (i < S + CP) begin : g_c
        assign nxt[w*N+i] = cy[(w-1)*G+i-S];
      end else begin : g_z
        assign nxt[w*N+i] = 1'b0;
      end
    end
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
    end
    always_ff @(posedge clk) out_bits <= nxt;

    // R5: one cycle per registered pass, nothing dropped or invented
    p_valid_step_r5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    p_valid_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R6: reset empties this stage on the next cycle
    p_reset_clear_r6: assert property (@(posedge clk) rst |=> !out_valid);
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_bits  = nxt;
  end

  // R3: the pass conserves the weighted value of its bits
  p_level_sum_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> wsum(nxt) == wsum(in_bits));
  // R3: no carry escapes above the top column
  p_top_carry_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> cy[(W-1)*G +: G] == '0);

endmodule

// File: rtl/popc_out.sv
module popc_out #(
  parameter int N   = 32,
  parameter int W   = 6,
  parameter bit SAT = 1'b0
) (
  input  logic [W*N-1:0] in_bits,
  output logic [W-1:0]   raw_count,
  output logic [W-1:0]   out_count,
  output logic           out_over
);
  // After the last pass each column holds at most one set bit.
  for (genvar w = 0; w < W; w++) begin : g_bit
    assign raw_count[w] = |in_bits[w*N +: N];
  end

  assign out_over = |raw_count[W-1:2];

  if (SAT) begin : g_sat
    assign out_count = out_over ? W'(3) : {{(W-2){1'b0}}, raw_count[1:0]};
  end else begin : g_full
    assign out_count = raw_count;
  end
endmodule

// File: rtl/popc_csa.sv
module popc_csa #(
  parameter int          N         = 32,
  parameter logic [31:0] PIPE_MASK = 32'h0000_0005,
  parameter bit          SATURATE  = 1'b0,
  localparam int         CW        = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [N-1:0]  in_word,
  output logic          out_valid,
  output logic [CW-1:0] out_count,
  output logic          out_over
);
  localparam int LEVELS = popc_pkg::tree_levels(N, CW);

  logic [CW*N-1:0] stage_bits [LEVELS+1];
  logic            stage_v    [LEVELS+1];
  logic [CW-1:0]   raw_count;   // unclamped tree result, brought out for checks

  assign stage_bits[0] = {{((CW-1)*N){1'b0}}, in_word};
  assign stage_v[0]    = in_valid;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam bit RG = (l < 32) ? PIPE_MASK[l % 32] : 1'b0;
    popc_level #(.N(N), .W(CW), .LVL(l), .REG(RG)) u_level (
      .clk      (clk),
      .rst      (rst),
      .in_valid (stage_v[l]),
      .in_bits  (stage_bits[l]),
      .out_valid(stage_v[l+1]),
      .out_bits (stage_bits[l+1])
    );
  end

  popc_out #(.N(N), .W(CW), .SAT(SATURATE)) u_out (
    .in_bits  (stage_bits[LEVELS]),
    .raw_count(raw_count),
    .out_count(out_count),
    .out_over (out_over)
  );

  assign out_valid = stage_v[LEVELS];

  // R7: flag from upper columns agrees with a magnitude compare
  p_over_flag_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_over == (raw_count > CW'(3)));

  if (SATURATE) begin : g_sat_chk
    // R8: clamped output
    p_sat_clamp_r8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_over ? (out_count == CW'(3)) : (out_count == raw_count)));
  end

endmodule

// File: tb/popc_csa_tb.sv
module popc_csa_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // u_dut: N=32, passes 0 and 2 registered (K=2), full count
  logic        va, ova, oovra;
  logic [31:0] wa;
  logic [5:0]  oca;
  popc_csa #(.N(32), .PIPE_MASK(32'h5), .SATURATE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .in_valid(va), .in_word(wa),
    .out_valid(ova), .out_count(oca), .out_over(oovra));

  // u_dut_b: N=10 (one spare bit), combinational
  logic        vb, ovb, oovrb;
  logic [9:0]  wb;
  logic [3:0]  ocb;
  popc_csa #(.N(10), .PIPE_MASK(32'h0), .SATURATE(1'b0)) u_dut_b (
    .clk(clk), .rst(rst), .in_valid(vb), .in_word(wb),
    .out_valid(ovb), .out_count(ocb), .out_over(oovrb));

  // u_dut_c: N=11 (two spare bits), K=3, saturating
  logic        vc, ovc, oovrc;
  logic [10:0] wc;
  logic [3:0]  occ;
  popc_csa #(.N(11), .PIPE_MASK(32'h7), .SATURATE(1'b1)) u_dut_c (
    .clk(clk), .rst(rst), .in_valid(vc), .in_word(wc),
    .out_valid(ovc), .out_count(occ), .out_over(oovrc));

  // u_dut_d: N=64, combinational
  logic        vd, ovd, oovrd;
  logic [63:0] wd;
  logic [6:0]  ocd;
  popc_csa #(.N(64), .PIPE_MASK(32'h0), .SATURATE(1'b0)) u_dut_d (
    .clk(clk), .rst(rst), .in_valid(vd), .in_word(wd),
    .out_valid(ovd), .out_count(ocd), .out_over(oovrd));

  function automatic int ones(input logic [63:0] v);
    int t = 0;
    for (int i = 0; i < 64; i++) if (v[i] === 1'b1) t++;
    return t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // history rings for the pipelined instances
  bit ring_av [16];
  int ring_an [16];
  bit ring_cv [16];
  int ring_cn [16];

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      ring_av[i] = 1'b0; ring_an[i] = 0; ring_cv[i] = 1'b0; ring_cn[i] = 0;
    end
    // R6: valid held high through reset
    va = 1'b1; wa = '1; vc = 1'b1; wc = '1;
    vb = 1'b0; wb = '0; vd = 1'b0; wd = '0;
    repeat (4) @(negedge clk);
    check("R6 reset clears u_dut valid", int'(ova), 0);
    check("R6 reset clears u_dut_c valid", int'(ovc), 0);
    check("R2 width N=32", $bits(oca), 6);
    check("R2 width N=64", $bits(ocd), 7);
    check("R2 width N=11", $bits(occ), 4);
    va = 1'b0; vc = 1'b0;
    rst = 1'b0;

    // R4/R1/R7/R9: exhaustive N=10, combinational
    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      vb = 1'b1; wb = v[9:0];
      #2;
      check("R9 comb valid N=10", int'(ovb), 1);
      check("R4 count N=10 (spare bit)", int'(ocb), ones(64'(wb)));
      check("R7 over N=10", int'(oovrb), int'(ones(64'(wb)) > 3));
    end
    @(negedge clk); vb = 1'b0; #2;
    check("R9 comb idle N=10", int'(ovb), 0);

    // R1: N=64 special and random words
    for (int v = 0; v < 700; v++) begin
      @(negedge clk);
      vd = 1'b1;
      if (v == 0)       wd = '0;
      else if (v == 1)  wd = '1;
      else if (v < 66)  wd = 64'd1 << (v - 2);
      else if (v % 3 == 0) wd = {$urandom, $urandom} & {$urandom, $urandom};
      else              wd = {$urandom, $urandom};
      #2;
      check("R1 count N=64", int'(ocd), ones(wd));
      check("R7 over N=64", int'(oovrd), int'(ones(wd) > 3));
    end
    vd = 1'b0;

    // R5/R1/R8: streaming into the pipelined instances
    for (int c = 0; c < 2056; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        check("R5 valid delay K=2", int'(ova), int'(ring_av[(c-2)%16]));
        if (ring_av[(c-2)%16]) begin
          check("R1 count N=32", int'(oca), ring_an[(c-2)%16]);
          check("R7 over N=32", int'(oovra), int'(ring_an[(c-2)%16] > 3));
        end
      end else begin
        check("R5 no early valid K=2", int'(ova), 0);
      end
      if (c >= 3) begin
        check("R5 valid delay K=3", int'(ovc), int'(ring_cv[(c-3)%16]));
        if (ring_cv[(c-3)%16]) begin
          check("R8 clamp N=11", int'(occ),
                (ring_cn[(c-3)%16] > 3) ? 3 : ring_cn[(c-3)%16]);
          check("R7 over N=11", int'(oovrc), int'(ring_cn[(c-3)%16] > 3));
        end
      end else begin
        check("R5 no early valid K=3", int'(ovc), 0);
      end
      // drive next word
      va = (c < 2048) && (c % 7 != 3);
      if (c == 0)          wa = '0;
      else if (c == 1)     wa = '1;
      else if (c < 34)     wa = 32'd1 << (c - 2);
      else if (c % 5 == 0) wa = $urandom & $urandom & $urandom;
      else                 wa = $urandom;
      vc = (c < 2048);
      wc = c[10:0];
      ring_av[c%16] = va; ring_an[c%16] = ones(64'(wa));
      ring_cv[c%16] = vc; ring_cn[c%16] = ones(64'(wc));
    end

    // R6: reset in mid-stream with valid high
    @(negedge clk);
    va = 1'b1; wa = '1; vc = 1'b1; wc = '1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R6 mid-run reset u_dut", int'(ova), 0);
    check("R6 mid-run reset u_dut_c", int'(ovc), 0);
    rst = 1'b0; va = 1'b0; vc = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 drained u_dut", int'(ova), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule